// File: doc/BRIEF.md
# Queue-Occupancy Frequency Level Governor

This block chooses the voltage-frequency operating point of a checker core that re-runs work handed to it by a primary core. Two forwarding queues sit between the cores: one carries branch outcomes and the other carries instruction results. How full these queues are shows how far the checker core lags. When a queue fills, the checker is falling behind and needs a faster clock. When a queue runs nearly dry, the checker has slack and can run slower to save energy.

The block counts base time ticks. Every `intv_ticks` ticks it compares each occupancy count against that queue's own programmable low and high limits. It then moves a level index by at most one step within a table of `NUM_LVL` operating points. Index 0 is the lowest point, near 0.6 V. Index `NUM_LVL-1` is the nominal-frequency point, near 1.0 V. With a base tick of about 1 µs, the evaluation period runs from 1 µs up to millisecond scale. Each time the index actually moves, a one-cycle strobe is raised. The regulator and clock generator that act on the index are outside this block.

Top module: `qfill_dvfs_gov`

## Requirements
- R1: After reset the level index equals `NUM_LVL-1` (the nominal point), and the change strobe is 0.
- R2: At an evaluation, if the branch-queue count is strictly greater than its high limit, the level index rises by one.
- R3: At an evaluation, if the result-queue count is strictly greater than its high limit, the level index rises by one.
- R4: At an evaluation with no rise condition, if either count is strictly less than that queue's low limit, the level index falls by one.
- R5: If each count lies within its own low and high limits (inclusive), an evaluation leaves the level index unchanged and gives no strobe.
- R6: When a rise condition and a fall condition hold at the same evaluation, the index rises.
- R7: The index saturates at its ends. A rise request at `NUM_LVL-1` and a fall request at 0 leave it unchanged, with no strobe.
- R8: The change strobe `lvl_chg` is 1 for exactly the one cycle in which a new level index first appears. It is 0 at all other times.
- R9: An evaluation happens only on a cycle where `upd_tick` is 1, and only on every `intv_ticks`-th such tick. A value of 0 is treated as 1. On any cycle without an evaluation, the index holds.
- R10: One evaluation moves the index by at most one step, and the result appears on `lvl` on the clock edge that samples the evaluating tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_tick | input | 1 | One-cycle base time tick |
| intv_ticks | input | INTV_W | Number of ticks per evaluation (0 is treated as 1) |
| bq_occ | input | BQ_W | Branch outcome queue occupancy |
| rq_occ | input | RQ_W | Instruction result queue occupancy |
| bq_lo | input | BQ_W | Branch queue low limit |
| bq_hi | input | BQ_W | Branch queue high limit |
| rq_lo | input | RQ_W | Result queue low limit |
| rq_hi | input | RQ_W | Result queue high limit |
| lvl | output | LVL_W | Current operating point index, 0 = lowest |
| lvl_chg | output | 1 | One-cycle pulse when `lvl` changes |

## Verification
Each queue is driven above its high limit on its own. This shows that each queue can raise the level by itself. Counts placed exactly on the limits check that the comparisons are strict. A full queue together with an empty one shows that a rise wins over a fall. Repeated falls and a rise at the top drive the index into both ends and check that it saturates there with no strobe. Longer tick intervals, a zero interval and runs with no ticks show that only the counted ticks can move the level.

// File: rtl/qfill_dvfs_gov.sv
module qfill_dvfs_gov #(
  parameter int BQ_DEPTH = 64,
  parameter int RQ_DEPTH = 512,
  parameter int NUM_LVL  = 5,
  parameter int INTV_W   = 12,
  localparam int BQ_W  = $clog2(BQ_DEPTH + 1),
  localparam int RQ_W  = $clog2(RQ_DEPTH + 1),
  localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_tick,
  input  logic [INTV_W-1:0] intv_ticks,
  input  logic [BQ_W-1:0]   bq_occ,
  input  logic [RQ_W-1:0]   rq_occ,
  input  logic [BQ_W-1:0]   bq_lo,
  input  logic [BQ_W-1:0]   bq_hi,
  input  logic [RQ_W-1:0]   rq_lo,
  input  logic [RQ_W-1:0]   rq_hi,
  output logic [LVL_W-1:0]  lvl,
  output logic              lvl_chg
);

  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LVL - 1);

  logic [INTV_W-1:0] tick_cnt;
  logic [INTV_W-1:0] last_cnt;
  logic              eval;
  logic              go_up;
  logic              go_dn;
  logic [LVL_W-1:0]  lvl_q;
  logic [LVL_W-1:0]  lvl_d;

  assign last_cnt = (intv_ticks == '0) ? '0 : intv_ticks - INTV_W'(1);
  assign eval     = upd_tick && (tick_cnt >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tick_cnt <= '0;
    else if (upd_tick)
      tick_cnt <= (tick_cnt >= last_cnt) ? '0 : tick_cnt + INTV_W'(1);
  end

  assign go_up = (bq_occ > bq_hi) || (rq_occ > rq_hi);
  assign go_dn = (bq_occ < bq_lo) || (rq_occ < rq_lo);

  always_comb begin
    lvl_d = lvl_q;
    if (eval) begin
      if (go_up) begin
        if (lvl_q != TOP_LVL) lvl_d = lvl_q + LVL_W'(1);
      end else if (go_dn) begin
        if (lvl_q != '0) lvl_d = lvl_q - LVL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= TOP_LVL;
      lvl_chg <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      lvl_chg <= (lvl_d != lvl_q);
    end
  end

  assign lvl = lvl_q;

  // R7
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= TOP_LVL);

  // R10
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |->
      ((LVL_W'(lvl_q - $past(lvl_q)) == LVL_W'(1)) ||
       (LVL_W'($past(lvl_q) - lvl_q) == LVL_W'(1))));

  // R8
  strobe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_chg == (lvl_q != $past(lvl_q)));

  // R9
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_tick |=> $stable(lvl_q));

  // R6
  up_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && go_up) |=> (lvl_q >= $past(lvl_q)));

  // R4
  down_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !go_up && go_dn) |=> (lvl_q <= $past(lvl_q)));

endmodule

// File: tb/qfill_dvfs_gov_tb_top.sv
module qfill_dvfs_gov_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_LVL = 5;
  localparam int TOP = NUM_LVL - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_tick = 1'b0;
  logic [11:0] intv_ticks = 12'd1;
  logic [6:0]  bq_occ = 7'd20;
  logic [9:0]  rq_occ = 10'd200;
  logic [6:0]  bq_lo = 7'd8;
  logic [6:0]  bq_hi = 7'd48;
  logic [9:0]  rq_lo = 10'd64;
  logic [9:0]  rq_hi = 10'd400;
  logic [2:0]  lvl;
  logic        lvl_chg;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qfill_dvfs_gov #(.NUM_LVL(NUM_LVL)) dut_i (
    .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick), .intv_ticks(intv_ticks),
    .bq_occ(bq_occ), .rq_occ(rq_occ), .bq_lo(bq_lo), .bq_hi(bq_hi),
    .rq_lo(rq_lo), .rq_hi(rq_hi), .lvl(lvl), .lvl_chg(lvl_chg));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_occ(int b, int r);
    bq_occ = 7'(b);
    rq_occ = 10'(r);
  endtask

  task automatic pulse_tick();
    @(negedge clk) upd_tick = 1'b1;
    @(negedge clk) upd_tick = 1'b0;
  endtask

  task automatic step_and_check(string req, int exp_lvl, int exp_chg);
    pulse_tick();
    chk({req, " lvl"}, int'(lvl), exp_lvl);
    chk({req, " strobe"}, int'(lvl_chg), exp_chg);
  endtask

  task automatic t_reset();
    chk("R1 lvl", int'(lvl), TOP);
    chk("R1 strobe", int'(lvl_chg), 0);
  endtask

  task automatic t_top_sat();
    set_occ(60, 200);
    step_and_check("R7 top", TOP, 0);
  endtask

  task automatic t_lower();
    set_occ(20, 10);
    step_and_check("R4 rq low", TOP - 1, 1);
    @(negedge clk);
    chk("R8 strobe clears", int'(lvl_chg), 0);
    set_occ(3, 200);
    step_and_check("R4 bq low", TOP - 2, 1);
  endtask

  task automatic t_in_band();
    set_occ(8, 400);
    step_and_check("R5 low edges", TOP - 2, 0);
    set_occ(48, 64);
    step_and_check("R5 high edges", TOP - 2, 0);
  endtask

  task automatic t_raise();
    set_occ(49, 200);
    step_and_check("R2 bq high", TOP - 1, 1);
    set_occ(20, 401);
    step_and_check("R3 rq high", TOP, 1);
  endtask

  task automatic t_prio();
    set_occ(20, 0);
    step_and_check("R4 setup", TOP - 1, 1);
    set_occ(64, 0);
    step_and_check("R6 bq up rq down", TOP, 1);
    set_occ(0, 0);
    step_and_check("R4 both low", TOP - 1, 1);
    set_occ(0, 512);
    step_and_check("R6 rq up bq down", TOP, 1);
  endtask

  task automatic t_bottom_sat();
    set_occ(0, 0);
    for (int i = TOP - 1; i >= 0; i--)
      step_and_check("R10 single step down", i, 1);
    step_and_check("R7 bottom", 0, 0);
  endtask

  task automatic t_no_tick();
    set_occ(60, 500);
    repeat (6) @(negedge clk);
    chk("R9 no tick hold", int'(lvl), 0);
    chk("R9 no tick strobe", int'(lvl_chg), 0);
  endtask

  task automatic t_interval();
    intv_ticks = 12'd3;
    step_and_check("R9 tick 1 of 3", 0, 0);
    step_and_check("R9 tick 2 of 3", 0, 0);
    step_and_check("R9 tick 3 of 3", 1, 1);
    step_and_check("R9 next period 1", 1, 0);
    step_and_check("R9 next period 2", 1, 0);
    step_and_check("R9 next period 3", 2, 1);
    intv_ticks = 12'd0;
    step_and_check("R9 zero interval a", 3, 1);
    step_and_check("R9 zero interval b", 4, 1);
    intv_ticks = 12'd1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_top_sat();
    t_lower();
    t_in_band();
    t_raise();
    t_prio();
    t_bottom_sat();
    t_no_tick();
    t_interval();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule